// File: doc/BRIEF.md
# Interleaved I/Q Transmit Serializer

This block sits on the baseband side of a shared sample bus that is split into a transmit half and a receive half. It takes parallel two's-complement I and Q samples for one or two transmit channels through a valid/ready handshake. It then drives them onto the transmit half, one narrow word per clock at single data rate. Each sample becomes a high word and a low word. The words of one sample pair are interleaved as I-high, Q-high, I-low, Q-low. In dual-slot mode, the four words of the second channel follow those of the first. A frame marker runs alongside the data. It is either a level that spans the whole burst or a square wave that is high for the first half of every group.

When only one channel of a dual-slot group is enabled, the group length stays at eight words. The disabled channel's four positions carry filler. The filler is either a constant word or a copy of the enabled channel's word at the same position, which keeps the bus from toggling. New samples are taken only at group boundaries. A burst runs while the enable input is high. When enable drops, the group in flight is completed. When no sample is offered at a boundary, the bus and the frame marker return to idle.

Top module: `iq_tx_serializer`

## Requirements
- R1: A 12-bit sample S is sent as the word S[11:6] followed later in the group by the word S[5:0]. Bus bit 5 carries the more significant bit of each word.
- R2: With dualSlot=0, a group is 4 words: I0-high, Q0-high, I0-low, Q0-low. The first word is on the bus in the cycle that follows the accepting clock edge.
- R3: With dualSlot=1 and chanMask=2'b11, a group is 8 words: channel 0's 4-word pattern followed by channel 1's (I1 from sI1, Q1 from sQ1).
- R4: With dualSlot=1, a slot whose chanMask bit is 0 (bit 0 = channel 0, bit 1 = channel 1) is filler. The group still lasts 8 cycles and the enabled slot keeps its positions.
- R5: With fillRepeat=0, a filler word equals FILL_WORD (default 0). With fillRepeat=1 and the other channel enabled, a filler word equals the other channel's word at the same position (0 to 3) of its slot.
- R6: With framePeriodic=0, frameOut is 1 in every cycle of a burst and 0 when idle.
- R7: With framePeriodic=1, frameOut is 1 for the first half of every group (2 of 4 or 4 of 8 words) and 0 for the second half.
- R8: sRdy is 1 only when burstEn is 1 and the block is either idle or on the last word of a group. A sample set (and the configuration inputs) is taken on a clock edge where sVal and sRdy are both 1. Back-to-back groups carry no gap.
- R9: If no sample set is taken at the end of a group, the next cycle is idle: busWord is 0 and frameOut is 0.
- R10: Dropping burstEn in the middle of a group does not cut it short. All its words are sent, then the block goes idle.
- R11: Full-scale positive 0x7FF is sent as 0x1F then 0x3F. Full-scale negative 0x800 is sent as 0x20 then 0x00.
- R12: After reset, busWord is 0, frameOut is 0 and sRdy equals burstEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| burstEn | input | 1 | Burst enable; while high, new groups may start |
| dualSlot | input | 1 | 1 selects the 8-word two-slot group, 0 the 4-word group |
| chanMask | input | 2 | Per-slot channel enable in dual-slot mode |
| framePeriodic | input | 1 | 1 selects the half-group square frame, 0 the burst-long level |
| fillRepeat | input | 1 | 1 fills disabled slots with the other slot's words, 0 with the constant |
| sVal | input | 1 | Sample set valid |
| sRdy | output | 1 | Sample set accepted on this edge when sVal is high |
| sI0 | input | 12 | Channel 0 in-phase sample |
| sQ0 | input | 12 | Channel 0 quadrature sample |
| sI1 | input | 12 | Channel 1 in-phase sample |
| sQ1 | input | 12 | Channel 1 quadrature sample |
| busWord | output | 6 | Transmit half of the shared data bus |
| frameOut | output | 1 | Frame marker |

## Verification
The outputs are decoded without further delay from the registers that the accepting edge loads. Word k of a group is therefore due k cycles after the first falling edge that follows the accepting rising edge. The idle state is due one cycle after the last word. sRdy is combinational and is due in the same cycle as the slot it belongs to. The bench drives every input and samples every output on the falling edge. It steps exactly one cycle per word and compares each word and frame value with the position it expects.

// File: rtl/iqser_pkg.sv
package iqser_pkg;

  localparam int SLOT_W = 3;
  localparam int POS_W  = 2;

  typedef struct packed {
    logic             load;
    logic             active;
    logic             chSel;
    logic [POS_W-1:0] pos;
    logic             fill;
    logic             useOther;
  } iqser_strobe_t;

endpackage

// File: rtl/iqser_ctrl.sv
module iqser_ctrl
  import iqser_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          burstEn,
  input  logic          sVal,
  input  logic          dualSlot,
  input  logic [1:0]    chanMask,
  input  logic          framePeriodic,
  input  logic          fillRepeat,
  output logic          sRdy,
  output logic          frameOut,
  output iqser_strobe_t strb
);

  localparam logic [SLOT_W-1:0] LAST_SINGLE = SLOT_W'(3);
  localparam logic [SLOT_W-1:0] LAST_DUAL   = SLOT_W'(7);

  logic              active;
  logic [SLOT_W-1:0] slot;
  logic              dualQ;
  logic [1:0]        maskQ;
  logic              periodicQ;
  logic              repeatQ;
  logic              lastSlot;
  logic              accept;
  logic              chSel;
  logic              firstHalf;

  assign lastSlot = dualQ ? (slot == LAST_DUAL) : (slot == LAST_SINGLE);
  assign sRdy     = burstEn && (!active || lastSlot);
  assign accept   = sRdy && sVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      slot      <= '0;
      dualQ     <= 1'b0;
      maskQ     <= '0;
      periodicQ <= 1'b0;
      repeatQ   <= 1'b0;
    end else if (accept) begin
      active    <= 1'b1;
      slot      <= '0;
      dualQ     <= dualSlot;
      maskQ     <= chanMask;
      periodicQ <= framePeriodic;
      repeatQ   <= fillRepeat;
    end else if (active && !lastSlot) begin
      slot <= slot + SLOT_W'(1);
    end else if (active) begin
      active <= 1'b0;
      slot   <= '0;
    end
  end

  assign chSel     = dualQ & slot[2];
  assign firstHalf = dualQ ? !slot[2] : !slot[1];
  assign frameOut  = active && (periodicQ ? firstHalf : 1'b1);

  always_comb begin
    strb          = '0;
    strb.load     = accept;
    strb.active   = active;
    strb.chSel    = chSel;
    strb.pos      = slot[POS_W-1:0];
    strb.fill     = active && dualQ && !maskQ[chSel];
    strb.useOther = repeatQ && maskQ[~chSel];
  end

  // R8: an accepted set starts a group at word 0
  a_r8_accept_starts: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (active && slot == '0));

  // R2: words advance one per cycle inside a group; R10: no early stop
  a_r10_group_runs_on: assert property (@(posedge clk) disable iff (!rstN)
    (active && !lastSlot) |=> (active && slot == $past(slot) + SLOT_W'(1)));

  // R9: a starved boundary ends the burst
  a_r9_stop_when_starved: assert property (@(posedge clk) disable iff (!rstN)
    (active && lastSlot && !accept) |=> !active);

  // R3: the slot counter never leaves the group
  a_r3_slot_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (!dualQ && active) |-> (slot <= LAST_SINGLE));

endmodule

// File: rtl/iqser_datapath.sv
module iqser_datapath
  import iqser_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter logic [SAMPLE_W/2-1:0] FILL_WORD = '0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  iqser_strobe_t                strb,
  input  logic [1:0][SAMPLE_W-1:0]     iIn,
  input  logic [1:0][SAMPLE_W-1:0]     qIn,
  output logic [SAMPLE_W/2-1:0]        busWord
);

  localparam int WORD_W = SAMPLE_W / 2;
  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0][SAMPLE_W-1:0] iReg;
  logic [NUM_CH-1:0][SAMPLE_W-1:0] qReg;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        iReg[ch] <= '0;
        qReg[ch] <= '0;
      end else if (strb.load) begin
        iReg[ch] <= iIn[ch];
        qReg[ch] <= qIn[ch];
      end
    end
  end

  logic              srcCh;
  logic [SAMPLE_W-1:0] srcSample;
  logic [WORD_W-1:0] halfWord;

  always_comb begin
    srcCh     = strb.fill ? ~strb.chSel : strb.chSel;
    srcSample = strb.pos[0] ? qReg[srcCh] : iReg[srcCh];
    halfWord  = strb.pos[1] ? srcSample[WORD_W-1:0]
                            : srcSample[SAMPLE_W-1:WORD_W];
    if (!strb.active)
      busWord = '0;
    else if (strb.fill && !strb.useOther)
      busWord = FILL_WORD;
    else
      busWord = halfWord;
  end

endmodule

// File: rtl/iq_tx_serializer.sv
module iq_tx_serializer
  import iqser_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter logic [SAMPLE_W/2-1:0] FILL_WORD = '0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  burstEn,
  input  logic                  dualSlot,
  input  logic [1:0]            chanMask,
  input  logic                  framePeriodic,
  input  logic                  fillRepeat,
  input  logic                  sVal,
  output logic                  sRdy,
  input  logic [SAMPLE_W-1:0]   sI0,
  input  logic [SAMPLE_W-1:0]   sQ0,
  input  logic [SAMPLE_W-1:0]   sI1,
  input  logic [SAMPLE_W-1:0]   sQ1,
  output logic [SAMPLE_W/2-1:0] busWord,
  output logic                  frameOut
);

  iqser_strobe_t strb;

  iqser_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .burstEn       (burstEn),
    .sVal          (sVal),
    .dualSlot      (dualSlot),
    .chanMask      (chanMask),
    .framePeriodic (framePeriodic),
    .fillRepeat    (fillRepeat),
    .sRdy          (sRdy),
    .frameOut      (frameOut),
    .strb          (strb)
  );

  iqser_datapath #(
    .SAMPLE_W  (SAMPLE_W),
    .FILL_WORD (FILL_WORD)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .iIn     ({sI1, sI0}),
    .qIn     ({sQ1, sQ0}),
    .busWord (busWord)
  );

  // R12: idle means a quiet bus and a low frame
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |-> (busWord == '0 && !frameOut));

  // R7: the frame only rises on the first word of a group
  a_r7_frame_rise_at_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameOut) |-> (strb.pos == '0 && !strb.chSel));

endmodule

// File: tb/iq_tx_serializer_tb_top.sv
module iq_tx_serializer_tb_top;

  localparam int SW = 12;
  localparam int WW = SW / 2;
  localparam int NVEC = 8;
  localparam int WATCHDOG = 20000;

  // layout: [52] dual, [51:50] mask, [49] repeat, [48] periodic,
  //         [47:36] I0, [35:24] Q0, [23:12] I1, [11:0] Q1
  localparam logic [52:0] VECS [0:NVEC-1] = '{
    {1'b0, 2'b01, 1'b0, 1'b0, 12'h7FF, 12'h800, 12'h000, 12'h000},
    {1'b0, 2'b01, 1'b0, 1'b1, 12'h123, 12'hA5C, 12'h000, 12'h000},
    {1'b1, 2'b11, 1'b0, 1'b1, 12'h456, 12'h789, 12'hABC, 12'hDEF},
    {1'b1, 2'b01, 1'b0, 1'b0, 12'hFFF, 12'h001, 12'h555, 12'hAAA},
    {1'b1, 2'b01, 1'b1, 1'b1, 12'h3C3, 12'hC3C, 12'h555, 12'hAAA},
    {1'b1, 2'b10, 1'b1, 1'b0, 12'h111, 12'h222, 12'h9E1, 12'h60F},
    {1'b1, 2'b10, 1'b0, 1'b1, 12'h111, 12'h222, 12'h800, 12'h7FF},
    {1'b1, 2'b00, 1'b1, 1'b0, 12'h321, 12'h654, 12'h987, 12'hCBA}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          burstEn = 1'b0;
  logic          dualSlot = 1'b0;
  logic [1:0]    chanMask = 2'b00;
  logic          framePeriodic = 1'b0;
  logic          fillRepeat = 1'b0;
  logic          sVal = 1'b0;
  logic          sRdy;
  logic [SW-1:0] sI0 = '0, sQ0 = '0, sI1 = '0, sQ1 = '0;
  logic [WW-1:0] busWord;
  logic          frameOut;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  iq_tx_serializer dut_i (
    .clk(clk), .rstN(rstN), .burstEn(burstEn), .dualSlot(dualSlot),
    .chanMask(chanMask), .framePeriodic(framePeriodic), .fillRepeat(fillRepeat),
    .sVal(sVal), .sRdy(sRdy), .sI0(sI0), .sQ0(sQ0), .sI1(sI1), .sQ1(sQ1),
    .busWord(busWord), .frameOut(frameOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] wordOf(input logic [52:0] v, input int ch, input int pos);
    logic [SW-1:0] s;
    if (ch == 0) s = pos[0] ? v[35:24] : v[47:36];
    else         s = pos[0] ? v[11:0]  : v[23:12];
    return pos[1] ? s[WW-1:0] : s[SW-1:WW];
  endfunction

  function automatic logic [WW-1:0] expWord(input logic [52:0] v, input int k);
    int ch = v[52] ? (k / 4) : 0;
    int pos = k % 4;
    logic enOwn = v[52] ? v[50 + ch] : 1'b1;
    logic enOther = v[52] ? v[50 + (1 - ch)] : 1'b0;
    if (enOwn) return wordOf(v, ch, pos);
    if (v[49] && enOther) return wordOf(v, 1 - ch, pos);
    return '0;
  endfunction

  function automatic logic expFrame(input logic [52:0] v, input int k);
    int gl = v[52] ? 8 : 4;
    return v[48] ? (k < gl / 2) : 1'b1;
  endfunction

  function automatic string tagOf(input int idx);
    case (idx)
      0: return "R11 R1";
      1: return "R2 R1";
      2: return "R3";
      3: return "R4";
      4: return "R5 repeat";
      5: return "R5 R4 slot0 off";
      6: return "R4 const";
      default: return "R5 both off";
    endcase
  endfunction

  task automatic driveVec(input logic [52:0] v);
    dualSlot = v[52]; chanMask = v[51:50]; fillRepeat = v[49]; framePeriodic = v[48];
    sI0 = v[47:36]; sQ0 = v[35:24]; sI1 = v[23:12]; sQ1 = v[11:0];
  endtask

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 busWord", 32'(busWord), 32'h0);
    chk("R12 frameOut", 32'(frameOut), 32'h0);
    chk("R12 sRdy without enable", 32'(sRdy), 32'h0);
    burstEn = 1'b1;
    #1;
    chk("R12 sRdy with enable", 32'(sRdy), 32'h1);

    // table walk: one group per vector, then starvation to idle
    for (int i = 0; i < NVEC; i++) begin
      int gl;
      @(negedge clk);
      driveVec(VECS[i]);
      burstEn = 1'b1;
      sVal = 1'b1;
      gl = VECS[i][52] ? 8 : 4;
      #1;
      chk("R8 ready when idle", 32'(sRdy), 32'h1);
      @(negedge clk);
      sVal = 1'b0;
      for (int k = 0; k < gl; k++) begin
        chk(tagOf(i), 32'(busWord), 32'(expWord(VECS[i], k)));
        chk(VECS[i][48] ? "R7 frame" : "R6 frame", 32'(frameOut),
            32'(expFrame(VECS[i], k)));
        chk("R8 ready only at boundary", 32'(sRdy), 32'(k == gl - 1));
        if (k < gl - 1) @(negedge clk);
      end
      @(negedge clk);
      chk("R9 idle bus", 32'(busWord), 32'h0);
      chk("R9 idle frame", 32'(frameOut), 32'h0);
    end

    // R8: back-to-back groups, second set taken at the last word
    begin
      logic [52:0] va = {1'b0, 2'b01, 1'b0, 1'b1, 12'h5A5, 12'h0F0, 12'h000, 12'h000};
      logic [52:0] vb = {1'b0, 2'b01, 1'b0, 1'b1, 12'hE38, 12'h1C7, 12'h000, 12'h000};
      @(negedge clk);
      driveVec(va);
      sVal = 1'b1;
      @(negedge clk);
      driveVec(vb);
      for (int k = 0; k < 4; k++) begin
        chk("R8 first group word", 32'(busWord), 32'(expWord(va, k)));
        if (k < 3) @(negedge clk);
      end
      @(negedge clk);
      sVal = 1'b0;
      for (int k = 0; k < 4; k++) begin
        chk("R8 back-to-back word", 32'(busWord), 32'(expWord(vb, k)));
        chk("R7 back-to-back frame", 32'(frameOut), 32'(k < 2));
        if (k < 3) @(negedge clk);
      end
      @(negedge clk);
      chk("R9 idle after back-to-back", 32'(busWord), 32'h0);
    end

    // R10: enable dropped mid-group with data still offered
    begin
      logic [52:0] vc = {1'b1, 2'b11, 1'b0, 1'b0, 12'h2B4, 12'hD4B, 12'h6E1, 12'h91E};
      @(negedge clk);
      driveVec(vc);
      burstEn = 1'b1;
      sVal = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 8; k++) begin
        if (k == 1) burstEn = 1'b0;
        #1;
        chk("R10 word after enable drop", 32'(busWord), 32'(expWord(vc, k)));
        chk("R10 frame after enable drop", 32'(frameOut), 32'h1);
        if (k >= 1) chk("R10 no ready", 32'(sRdy), 32'h0);
        if (k < 7) @(negedge clk);
      end
      @(negedge clk);
      chk("R10 idle bus", 32'(busWord), 32'h0);
      chk("R10 idle frame", 32'(frameOut), 32'h0);
      sVal = 1'b0;
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule